// File: doc/BRIEF.md
# Multiplexed Segment LCD Waveform Sequencer

This block drives a multiplexed segment LCD with 40 frontplane pins and up to four backplane pins. A host fills a 160-bit display memory over a byte-wide register bus, one bit per segment, and sets a global enable, a prescaler field and a duty/bias mode. While enabled, a prescaler divides the block clock down to an LCD tick. Each tick moves a backplane phase counter forward. When the last active backplane has had its phase, the frame ends and the drive polarity flips, which keeps the mean voltage across every segment at zero.

For every pin, in every phase, the block emits a 2-bit index (V0 to V3) that names the voltage level the pin should sit at. An analog stage outside this block turns those indices into voltages. While the global enable is low, every pin sits at V0 and the display memory is ordinary read/write storage. Each frontplane also has its own enable. A frontplane enabled while the global enable is low stays at V0 until the global enable is set. A frontplane enabled while the driver runs starts its waveform at once.

Top module: `lcd_seq_top`

## Requirements
- R1: After reset, the control byte and all frontplane-enable bytes read 0, and every frontplane and backplane pin outputs level index 0 (V0).
- R2: Display memory byte k, at bus address k for k from 0 to 19, holds frontplane 2k in bits 3..0 and frontplane 2k+1 in bits 7..4, with bit b of each nibble belonging to backplane b. A read returns the byte on `bus_rdata` one clock after the request. The memory reads and writes while the global enable is 0, and writing the global enable on or off leaves its contents unchanged.
- R3: The frontplane-enable bytes sit at addresses 0x40 to 0x44, and bit i of byte j enables frontplane 8j+i. The control byte sits at 0x7F, with bit 0 as the global enable, bits 3..1 as the prescaler field and bits 6..4 as the mode. All of these read back as written, and any unmapped address reads 0.
- R4: While the global enable is 0, every pin outputs V0, and the prescaler and phase counter are held at zero. The first phase after the enable is set is phase 0, with even polarity.
- R5: With prescaler field F, the phase advances every 2^(PRE_BASE+F) clocks. The first advance happens that many clocks after the clock edge that writes the enable.
- R6: Mode 0 is 1/1 duty at 1/1 bias (top level V1). Mode 1 is 1/2 duty at 1/2 bias (top V2). Mode 2 is 1/2 duty at 1/3 bias (top V3). Mode 3 is 1/3 duty at 1/3 bias (top V3). Mode 4 is 1/4 duty at 1/3 bias (top V3). The phase runs from 0 to duty-1, and the polarity flips each time the phase wraps to 0.
- R7: The backplane whose index equals the current phase outputs the top level at even polarity and V0 at odd polarity. The other active backplanes output V1 at 1/2 bias; at 1/3 bias they output V1 at even polarity and V2 at odd polarity. Backplanes with an index at or above the duty output V0.
- R8: An enabled frontplane whose memory bit for the current backplane is 1 (ON) outputs V0 at even polarity and the top level at odd polarity. A 0 bit (OFF) at 1/3 bias gives V2 at even polarity and V1 at odd polarity. A 0 bit at 1/1 or 1/2 bias gives the top level at even polarity and V0 at odd polarity.
- R9: A frontplane whose enable bit is 0 outputs V0. Setting its enable while the global enable is 1 makes its waveform appear directly after the clock edge that writes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the prescaler counts its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register bus request strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one clock after a read request |
| fp_lvl | output | 80 | Level index per frontplane; frontplane f uses bits 2f+1..2f |
| bp_lvl | output | 8 | Level index per backplane; backplane b uses bits 2b+1..2b |

## Verification
The assertions check five things on every cycle. All pins sit at V0 while the driver is off. The phase stays below the active duty. The phase moves only on a prescaler tick. The polarity flips on each frame wrap. Backplanes beyond the duty stay at V0. Only the bench's scenarios can show the level indices produced for each mode, phase and polarity, the segment-to-bit mapping, the exact tick period for a given prescaler field, the register readback and the survival of memory contents across enable toggles. The bench compares each of these against values it computes arithmetically from the requirements.

// File: rtl/lcd_seq_pkg.sv
`timescale 1ns/1ps
// lcd_seq_pkg: shared types and level rules for the LCD waveform sequencer.
// Assumes at most four backplanes and level indices V0..V3.
package lcd_seq_pkg;

    localparam int BP_MAX = 4;

    typedef logic [1:0] lvl_t;

    typedef struct packed {
        logic [2:0] duty;   // number of active backplanes, 1..4
        lvl_t       top;    // highest level index used by the bias
    } mode_cfg_t;

    // Map the 3-bit mode field to duty and bias top level.
    function automatic mode_cfg_t decode_mode(input logic [2:0] m);
        mode_cfg_t c;
        case (m)
            3'd0:    c = '{duty: 3'd1, top: 2'd1};
            3'd1:    c = '{duty: 3'd2, top: 2'd2};
            3'd2:    c = '{duty: 3'd2, top: 2'd3};
            3'd3:    c = '{duty: 3'd3, top: 2'd3};
            default: c = '{duty: 3'd4, top: 2'd3};
        endcase
        return c;
    endfunction

    // Backplane level: selected or unselected, per polarity.
    function automatic lvl_t bp_level(input logic sel, input logic odd, input lvl_t top);
        if (sel)
            return odd ? 2'd0 : top;
        if (top == 2'd3)
            return odd ? 2'd2 : 2'd1;
        return 2'd1;
    endfunction

    // Frontplane level: segment ON or OFF, per polarity.
    function automatic lvl_t fp_level(input logic on, input logic odd, input lvl_t top);
        if (on)
            return odd ? top : 2'd0;
        if (top == 2'd3)
            return odd ? 2'd1 : 2'd2;
        return odd ? 2'd0 : top;
    endfunction

endpackage

// File: rtl/lcd_seq_regs.sv
`timescale 1ns/1ps
// lcd_seq_regs: register bus decode, display memory, frontplane enables
// and control byte. Memory has no reset (contents undefined until written);
// read data is registered, one clock after the request.
// Assumes NUM_FP is even and a multiple of 8.
module lcd_seq_regs #(
    parameter int NUM_FP = 40,
    parameter int AW     = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [AW-1:0]       bus_addr,
    input  logic [7:0]          bus_wdata,
    output logic [7:0]          bus_rdata,
    output logic [NUM_FP*4-1:0] seg_bits,
    output logic [NUM_FP-1:0]   fp_en,
    output logic                glob_en,
    output logic [2:0]          pre_sel,
    output logic [2:0]          mode
);
    localparam int NB  = NUM_FP / 2;
    localparam int EB  = (NUM_FP + 7) / 8;
    localparam int MIW = (NB > 1) ? $clog2(NB) : 1;
    localparam int EIW = (EB > 1) ? $clog2(EB) : 1;
    localparam logic [AW-1:0] ENA_BASE = AW'(64);
    localparam logic [AW-1:0] CTL_ADDR = AW'(127);

    logic [7:0] mem    [NB];
    logic [7:0] fpen_q [EB];
    logic       en_q;
    logic [2:0] pre_q;
    logic [2:0] mode_q;

    logic            is_mem, is_ena, is_ctl;
    logic [AW-1:0]   ena_off;
    logic [MIW-1:0]  mem_idx;
    logic [EIW-1:0]  ena_idx;
    logic [7:0]      rd_next;

    // Address decode for the three register groups.
    always_comb begin
        ena_off = bus_addr - ENA_BASE;
        is_mem  = (bus_addr < AW'(NB));
        is_ena  = (bus_addr >= ENA_BASE) && (ena_off < AW'(EB));
        is_ctl  = (bus_addr == CTL_ADDR);
        mem_idx = bus_addr[MIW-1:0];
        ena_idx = ena_off[EIW-1:0];
    end

    // Display memory writes; no reset by design.
    always_ff @(posedge clk) begin
        if (bus_sel && bus_wr && is_mem)
            mem[mem_idx] <= bus_wdata;
    end

    // Frontplane enable bytes and control byte, reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < EB; j++)
                fpen_q[j] <= 8'h00;
            en_q   <= 1'b0;
            pre_q  <= 3'd0;
            mode_q <= 3'd0;
        end else if (bus_sel && bus_wr) begin
            if (is_ena)
                fpen_q[ena_idx] <= bus_wdata;
            if (is_ctl) begin
                en_q   <= bus_wdata[0];
                pre_q  <= bus_wdata[3:1];
                mode_q <= bus_wdata[6:4];
            end
        end
    end

    // Read data selection.
    always_comb begin
        rd_next = 8'h00;
        if (is_mem)
            rd_next = mem[mem_idx];
        else if (is_ena)
            rd_next = fpen_q[ena_idx];
        else if (is_ctl)
            rd_next = {1'b0, mode_q, pre_q, en_q};
    end

    // Registered read data, updated on each read request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= 8'h00;
        else if (bus_sel && !bus_wr)
            bus_rdata <= rd_next;
    end

    genvar f;
    generate
        for (f = 0; f < NUM_FP; f++) begin : g_fp
            assign seg_bits[f*4 +: 4] = mem[f/2][(f%2)*4 +: 4];
            assign fp_en[f]           = fpen_q[f/8][f%8];
        end
    endgenerate

    assign glob_en = en_q;
    assign pre_sel = pre_q;
    assign mode    = mode_q;

endmodule

// File: rtl/lcd_seq_timer.sv
`timescale 1ns/1ps
// lcd_seq_timer: prescaler and backplane phase / frame polarity counter.
// One tick every 2^(PRE_BASE+pre_sel) clocks; the phase wraps at duty-1,
// and the polarity flips on the wrap. Everything is held at zero while
// en is low. Assumes duty is 1..4.
module lcd_seq_timer #(
    parameter int PRE_BASE = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [2:0] pre_sel,
    input  logic [2:0] duty,
    output logic       tick,
    output logic [1:0] phase,
    output logic       parity
);
    localparam int CW = PRE_BASE + 8;

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit_m1;
    logic          last_phase;

    // Terminal count for the selected power-of-two divider.
    always_comb begin
        limit_m1   = (CW'(1) << (PRE_BASE + int'(pre_sel))) - CW'(1);
        tick       = en && (cnt == limit_m1);
        last_phase = ({1'b0, phase} >= (duty - 3'd1));
    end

    // Prescaler counter, cleared while disabled and on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || tick)
            cnt <= '0;
        else
            cnt <= cnt + CW'(1);
    end

    // Phase counter and frame polarity.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            phase  <= 2'd0;
            parity <= 1'b0;
        end else if (tick) begin
            if (last_phase) begin
                phase  <= 2'd0;
                parity <= ~parity;
            end else begin
                phase  <= phase + 2'd1;
            end
        end
    end

endmodule

// File: rtl/lcd_seq_wave.sv
`timescale 1ns/1ps
// lcd_seq_wave: per-pin level index generation from the segment bits,
// current phase, frame polarity and bias. Purely combinational.
// Assumes four backplane columns per frontplane in seg_bits.
module lcd_seq_wave
    import lcd_seq_pkg::*;
#(
    parameter int NUM_FP = 40
) (
    input  logic                  en,
    input  logic [NUM_FP-1:0]     fp_en,
    input  logic [NUM_FP*4-1:0]   seg_bits,
    input  logic [1:0]            phase,
    input  logic                  parity,
    input  logic [2:0]            duty,
    input  lvl_t                  top,
    output logic [NUM_FP*2-1:0]   fp_lvl,
    output logic [BP_MAX*2-1:0]   bp_lvl
);
    genvar f, b;
    generate
        for (f = 0; f < NUM_FP; f++) begin : g_fp
            logic [3:0] col;
            // Select this frontplane's bit for the active backplane.
            always_comb begin
                col = seg_bits[f*4 +: 4];
                fp_lvl[f*2 +: 2] = (en && fp_en[f]) ? fp_level(col[phase], parity, top) : 2'd0;
            end
        end
        for (b = 0; b < BP_MAX; b++) begin : g_bp
            // Backplane drive: selected, unselected or unused.
            always_comb begin
                if (!en || (duty <= 3'(b)))
                    bp_lvl[b*2 +: 2] = 2'd0;
                else
                    bp_lvl[b*2 +: 2] = bp_level(phase == 2'(b), parity, top);
            end
        end
    endgenerate

endmodule

// File: rtl/lcd_seq_top.sv
`timescale 1ns/1ps
// lcd_seq_top: multiplexed segment LCD waveform sequencer.
// Registers and memory, prescaler/phase timer and pin level generation.
// Synchronous active-low reset; outputs are level indices, not voltages.
module lcd_seq_top
    import lcd_seq_pkg::*;
#(
    parameter int NUM_FP   = 40,
    parameter int PRE_BASE = 16,
    parameter int AW       = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [AW-1:0]        bus_addr,
    input  logic [7:0]           bus_wdata,
    output logic [7:0]           bus_rdata,
    output logic [NUM_FP*2-1:0]  fp_lvl,
    output logic [BP_MAX*2-1:0]  bp_lvl
);
    logic [NUM_FP*4-1:0] seg_bits;
    logic [NUM_FP-1:0]   fp_en;
    logic                glob_en;
    logic [2:0]          pre_sel;
    logic [2:0]          mode;
    mode_cfg_t           cfg;
    logic [2:0]          duty;
    lvl_t                top;
    logic                tick;
    logic [1:0]          phase;
    logic                parity;

    // Mode field to duty and bias.
    always_comb begin
        cfg  = decode_mode(mode);
        duty = cfg.duty;
        top  = cfg.top;
    end

    lcd_seq_regs #(.NUM_FP(NUM_FP), .AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .seg_bits (seg_bits),
        .fp_en    (fp_en),
        .glob_en  (glob_en),
        .pre_sel  (pre_sel),
        .mode     (mode)
    );

    lcd_seq_timer #(.PRE_BASE(PRE_BASE)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (glob_en),
        .pre_sel(pre_sel),
        .duty   (duty),
        .tick   (tick),
        .phase  (phase),
        .parity (parity)
    );

    lcd_seq_wave #(.NUM_FP(NUM_FP)) u_wave (
        .en      (glob_en),
        .fp_en   (fp_en),
        .seg_bits(seg_bits),
        .phase   (phase),
        .parity  (parity),
        .duty    (duty),
        .top     (top),
        .fp_lvl  (fp_lvl),
        .bp_lvl  (bp_lvl)
    );

endmodule

// File: rtl/lcd_seq_chk.sv
`timescale 1ns/1ps
// lcd_seq_chk: cycle-by-cycle properties of the sequencer, bound to the top.
module lcd_seq_chk #(
    parameter int NUM_FP = 40
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 en,
    input logic                 tick,
    input logic [1:0]           phase,
    input logic                 parity,
    input logic [2:0]           duty,
    input logic [NUM_FP*2-1:0]  fp_lvl,
    input logic [7:0]           bp_lvl
);
    // R4: driver off means every pin at V0.
    a_r4_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (fp_lvl == '0 && bp_lvl == '0));

    // R6: phase never reaches the duty.
    a_r6_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> ({1'b0, phase} < duty));

    // R5: phase moves only on a prescaler tick.
    a_r5_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> (!en || $stable(phase)));

    // R6: polarity flips when the last phase wraps.
    a_r6_parity_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && ({1'b0, phase} == duty - 3'd1)) |=> (!en || (parity != $past(parity))));

    genvar b;
    generate
        for (b = 0; b < 4; b++) begin : g_bp
            // R7: backplanes beyond the duty stay at V0.
            a_r7_unused_bp: assert property (@(posedge clk) disable iff (!rst_n)
                (duty <= 3'(b)) |-> (bp_lvl[b*2 +: 2] == 2'd0));
        end
    endgenerate

endmodule

bind lcd_seq_top lcd_seq_chk #(.NUM_FP(NUM_FP)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (glob_en),
    .tick  (tick),
    .phase (phase),
    .parity(parity),
    .duty  (duty),
    .fp_lvl(fp_lvl),
    .bp_lvl(bp_lvl)
);

// File: tb/lcd_seq_top_tb.sv
`timescale 1ns/1ps
module lcd_seq_top_tb;
    localparam int NFP   = 40;
    localparam int PBASE = 2;
    localparam int NB    = NFP / 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [NFP*2-1:0] fp_lvl;
    logic [7:0]  bp_lvl;

    int n_chk = 0, n_bad = 0, cyc = 0, en_cyc = 0;
    int cur_mode = 0, cur_field = 0;
    bit glob = 0, done = 0;
    logic [7:0] model [NB];
    bit fpen [NFP];

    lcd_seq_top #(.NUM_FP(NFP), .PRE_BASE(PBASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fp_lvl(fp_lvl), .bp_lvl(bp_lvl));

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = 7'(a); bus_wdata = 8'(d);
        @(posedge clk);
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = 7'(a);
        @(posedge clk);
        @(negedge clk);
        bus_sel = 0;
        d = int'(bus_rdata);
    endtask

    task automatic set_ctl(input int mode, input int field, input bit en);
        wr(127, (mode << 4) | (field << 1) | int'(en));
        cur_mode = mode; cur_field = field; glob = en;
        en_cyc = cyc;
    endtask

    function automatic int duty_of(input int m);
        return (m == 0) ? 1 : (m <= 2) ? 2 : (m == 3) ? 3 : 4;
    endfunction

    function automatic int top_of(input int m);
        return (m == 0) ? 1 : (m == 1) ? 2 : 3;
    endfunction

    function automatic int lim();
        return 1 << (PBASE + cur_field);
    endfunction

    // Compare all pins against levels computed from R7, R8, R9 and R4.
    task automatic check_now(input string tag);
        int duty, top, idx, p, par, exp, bitv;
        duty = duty_of(cur_mode);
        top  = top_of(cur_mode);
        idx  = (cyc - en_cyc) / lim();
        p    = idx % duty;
        par  = (idx / duty) % 2;
        for (int f = 0; f < NFP; f++) begin
            bitv = int'(model[f/2][(f%2)*4 + p]);
            if (!glob || !fpen[f]) exp = 0;
            else if (bitv == 1) exp = par ? top : 0;
            else if (top == 3) exp = par ? 1 : 2;
            else exp = par ? 0 : top;
            chk({tag, " fp"}, int'(fp_lvl[2*f +: 2]), exp);
        end
        for (int b = 0; b < 4; b++) begin
            if (!glob || b >= duty) exp = 0;
            else if (b == p) exp = par ? 0 : top;
            else if (top == 3) exp = par ? 2 : 1;
            else exp = 1;
            chk({tag, " bp"}, int'(bp_lvl[2*b +: 2]), exp);
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int d;
        for (int f = 0; f < NFP; f++) fpen[f] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1: reset state
        rd(127, d); chk("R1 ctl", d, 0);
        for (int j = 0; j < 5; j++) begin rd(64 + j, d); chk("R1 ena", d, 0); end
        chk("R1 fp_lvl", int'(fp_lvl != '0), 0);
        chk("R1 bp_lvl", int'(bp_lvl), 0);

        // R2: memory as plain RAM while off
        for (int k = 0; k < NB; k++) begin
            model[k] = 8'((k * 37 + 11) & 255);
            wr(k, int'(model[k]));
        end
        for (int k = 0; k < NB; k++) begin rd(k, d); chk("R2 mem", d, int'(model[k])); end
        set_ctl(2, 1, 1);
        set_ctl(0, 0, 0);
        for (int k = 0; k < NB; k++) begin rd(k, d); chk("R2 mem after enable toggle", d, int'(model[k])); end

        // R3: register map readback
        for (int j = 0; j < 5; j++) begin
            wr(64 + j, 255);
            for (int i = 0; i < 8; i++) fpen[8*j + i] = 1;
            rd(64 + j, d); chk("R3 ena", d, 255);
        end
        wr(127, 8'h5A); rd(127, d); chk("R3 ctl", d, 8'h5A);
        wr(127, 0);
        rd(48, d); chk("R3 unmapped", d, 0);

        // R4: enables set while off, all pins stay at V0
        glob = 0; check_now("R4 off");

        // R6, R7, R8: sweep all modes over two frames
        for (int m = 0; m < 5; m++) begin
            set_ctl(m, m % 2, 1);
            check_now("R4 first phase");
            repeat (lim() / 2) @(posedge clk);
            #1;
            for (int k = 0; k < 2 * duty_of(m); k++) begin
                check_now("R6,R7,R8 sweep");
                repeat (lim()) @(posedge clk);
                #1;
            end
            set_ctl(m, m % 2, 0);
            check_now("R4 disabled");
        end

        // R5: exact tick boundary with field 3
        set_ctl(4, 3, 1);
        repeat (lim() - 1) @(posedge clk);
        #1; check_now("R5 before tick");
        chk("R5 bp0 selected", int'(bp_lvl[1:0]), 3);
        @(posedge clk);
        #1; check_now("R5 after tick");
        chk("R5 bp1 selected", int'(bp_lvl[3:2]), 3);
        set_ctl(0, 0, 0);

        // R9: per-frontplane enable while running
        wr(64, 0);
        for (int i = 0; i < 8; i++) fpen[i] = 0;
        set_ctl(3, 0, 1);
        repeat (2) @(posedge clk);
        #1; check_now("R9 fp disabled");
        wr(64, 8'hA5);
        for (int i = 0; i < 8; i++) fpen[i] = ((8'hA5 >> i) & 1) != 0;
        check_now("R9 fp enabled live");
        repeat (5) @(posedge clk);
        #1; check_now("R9 fp running");

        // R2: memory kept after running
        set_ctl(0, 0, 0);
        for (int k = 0; k < NB; k++) begin rd(k, d); chk("R2 mem after run", d, int'(model[k])); end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule